// File: doc/BRIEF.md
# Event and Gated Pulse Counter

This block counts activity on one asynchronous input pin. In event mode each active edge of the pin adds one to an 8-bit count, and the prescaler plays no part. In gated mode the pin is a gate: the count advances on each tick of a prescaled system clock, but only while the pin is at its active level. A polarity control picks the active edge or level.

A sticky flag records input activity. In event mode the flag goes up on every counted edge. In gated mode it goes up when the gate closes. The flag stays up until a one-cycle clear strobe takes it down. The whole block runs on the system clock. Internal advances are one-cycle enables, and the block derives no clocks.

The interface has control and status pins only. There is no data stream, so the block has no valid/ready handshake and needs no back-pressure.

Top module: `evt_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count goes to 0, `in_flag` goes to 0, the held rate goes to 00 and the prescaler phase goes to 0.
- R2: `ext_in` passes through a two-flop synchronizer. A change on `ext_in` that is set up before rising edge k can first alter `count` or `in_flag` at edge k+2, and it does not alter them before that edge.
- R3: In event mode (`gate_mode`=0) the count rises by one for each active edge of the synchronized input. `polarity`=1 selects the rising edge and `polarity`=0 selects the falling edge.
- R4: In event mode the opposite edge leaves the count and the flag unchanged. The value of `rate_sel` also has no effect on counting in this mode.
- R5: In event mode `in_flag` is set on the same edge that counts an active edge.
- R6: In gated mode (`gate_mode`=1) the count rises by one on each prescaler tick while the synchronized input is at its active level, and does not change while the input is inactive. `polarity`=1 makes high the active level and `polarity`=0 makes low the active level.
- R7: The prescaler produces one tick every N cycles, where `rate_sel` 00 gives N=1, 01 gives N=4, 10 gives N=32 and 11 gives N=256.
- R8: In gated mode `in_flag` is set when the synchronized input goes from its active level to its inactive level.
- R9: Once set, `in_flag` stays set until a cycle in which `flag_clr` is high. If a set condition and `flag_clr` occur in the same cycle, the flag stays set.
- R10: The count is 8 bits wide and wraps from 255 to 0.
- R11: Input pulses with high and low phases of two clock cycles each are all counted.
- R12: Any change of `rate_sel` restarts the prescaler. After the change, the first tick comes a full N cycles later at the new ratio, so the first gated increment happens at the (N+1)th rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | 1 | Asynchronous external event/gate pin |
| rate_sel | input | 2 | Prescaler ratio select |
| gate_mode | input | 1 | 0 selects event mode, 1 selects gated mode |
| polarity | input | 1 | 1 selects rising edge or high level as active, 0 selects falling edge or low level |
| flag_clr | input | 1 | One-cycle strobe that clears the input flag |
| count | output | 8 | Running count value |
| in_flag | output | 1 | Sticky input activity flag |

## Verification
The bench drives `ext_in` on a falling clock edge. It treats the edge-based results (count and flag) as due on the third rising edge after that drive: two synchronizer stages, then the registered update. It checks that nothing has moved at the second edge and that the result is present after the third. Gated windows are chosen as whole multiples of the prescale period, so the expected number of increments does not depend on the prescaler phase. After a rate change, the bench checks that the count holds through N rising edges and moves on edge N+1.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    RATE_DIV1   = 2'b00,
    RATE_DIV4   = 2'b01,
    RATE_DIV32  = 2'b10,
    RATE_DIV256 = 2'b11
  } rate_e;

  // Terminal value of the prescaler counter (divide ratio minus one).
  function automatic logic [7:0] rate_last(input logic [1:0] sel);
    case (rate_e'(sel))
      RATE_DIV1:  rate_last = 8'd0;
      RATE_DIV4:  rate_last = 8'd3;
      RATE_DIV32: rate_last = 8'd31;
      default:    rate_last = 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_now,
  output logic sync_prev
);
  logic [STAGES-1:0] chain;
  logic              hist;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  // One extra stage of history for edge detection.
  always_ff @(posedge clk) begin
    if (rst) hist <= 1'b0;
    else     hist <= chain[STAGES-1];
  end

  assign sync_now  = chain[STAGES-1];
  assign sync_prev = hist;
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
  import evt_timer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [1:0]       rate_q;
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] last;
  logic             rate_chg;

  assign rate_chg = (rate_sel != rate_q);
  assign last     = PRE_W'(rate_last(rate_q));
  assign tick     = !rate_chg && (phase == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RATE_DIV1;
      phase  <= '0;
    end else begin
      rate_q <= rate_sel;
      if (rate_chg || tick) phase <= '0;
      else                  phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/evt_detect.sv
module evt_detect (
  input  logic sync_now,
  input  logic sync_prev,
  input  logic gate_mode,
  input  logic polarity,
  input  logic tick,
  output logic cnt_inc,
  output logic flag_set
);
  logic act_now;
  logic act_prev;

  assign act_now  = (sync_now  == polarity);
  assign act_prev = (sync_prev == polarity);

  always_comb begin
    if (gate_mode) begin
      cnt_inc  = act_now & tick;
      flag_set = act_prev & ~act_now;
    end else begin
      cnt_inc  = act_now & ~act_prev;
      flag_set = act_now & ~act_prev;
    end
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_inc,
  input  logic             flag_set,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (cnt_inc)       count <= count + 1'b1;
      if (flag_set)      flag  <= 1'b1;
      else if (flag_clr) flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 8,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_in,
  input  logic [1:0]       rate_sel,
  input  logic             gate_mode,
  input  logic             polarity,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             in_flag
);
  logic sync_now, sync_prev, tick, cnt_inc, flag_set;

  evt_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_in),
    .sync_now(sync_now), .sync_prev(sync_prev)
  );

  evt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .tick(tick)
  );

  evt_detect u_det (
    .sync_now(sync_now), .sync_prev(sync_prev), .gate_mode(gate_mode),
    .polarity(polarity), .tick(tick), .cnt_inc(cnt_inc), .flag_set(flag_set)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_inc(cnt_inc), .flag_set(flag_set),
    .flag_clr(flag_clr), .count(count), .flag(in_flag)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_in,
  input logic             gate_mode,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic             in_flag
);
  // R1: reset clears count and flag
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !in_flag));

  // R10: count only ever steps by one, wrapping modulo 2^CNT_W
  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> count == CNT_W'($past(count) + 1'b1));

  // R2/R3: in event mode a count step needs a pin change three/four samples back
  assert_event_source_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> ($past(gate_mode) || $past(rst, 3) || $past(rst, 4) ||
                         ($past(ext_in, 3) != $past(ext_in, 4))));

  // R5: an event-mode count step raises the flag on the same edge
  assert_event_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(count) && !$past(gate_mode)) |-> in_flag);

  // R9: flag holds without a clear strobe
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (in_flag && !flag_clr) |=> in_flag);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ext_in(ext_in), .gate_mode(gate_mode),
  .flag_clr(flag_clr), .count(count), .in_flag(in_flag)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_in = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       gate_mode = 1'b0;
  logic       polarity = 1'b1;
  logic       flag_clr = 1'b0;
  logic [7:0] count;
  logic       in_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .rate_sel(rate_sel),
    .gate_mode(gate_mode), .polarity(polarity), .flag_clr(flag_clr),
    .count(count), .in_flag(in_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic pulse_hi();
    ext_in = 1'b1; tick(2); ext_in = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 flag", in_flag, 0);
  endtask

  task automatic t_sync_latency();
    int c0 = count;
    ext_in = 1'b1; tick(2);
    chk("R2 count not yet", count, c0);
    chk("R2 flag not yet", in_flag, 0);
    tick(1);
    chk("R3 rising counted", count, (c0 + 1) % 256);
    chk("R5 flag on edge", in_flag, 1);
  endtask

  task automatic t_clear_and_opposite();
    int c0;
    clear_flag();
    chk("R9 cleared", in_flag, 0);
    c0 = count;
    ext_in = 1'b0; tick(4);
    chk("R4 falling ignored count", count, c0);
    chk("R4 falling ignored flag", in_flag, 0);
  endtask

  task automatic t_falling_polarity();
    int c0;
    polarity = 1'b0; tick(2);
    c0 = count;
    ext_in = 1'b1; tick(3);
    chk("R4 rising ignored pol0", count, c0);
    ext_in = 1'b0; tick(3);
    chk("R3 falling counted pol0", count, (c0 + 1) % 256);
    chk("R5 flag pol0", in_flag, 1);
    polarity = 1'b1; tick(2);
    clear_flag();
  endtask

  task automatic t_fast_pulses();
    int c0 = count;
    for (int i = 0; i < 10; i++) begin
      if (i == 5) rate_sel = 2'b11;
      pulse_hi();
    end
    tick(4);
    chk("R11 R4 ten narrow pulses", count, (c0 + 10) % 256);
    rate_sel = 2'b00;
  endtask

  task automatic t_wrap();
    int c0 = count;
    for (int i = c0; i < 255; i++) pulse_hi();
    tick(3);
    chk("R10 reach 255", count, 255);
    pulse_hi(); tick(3);
    chk("R10 wrap to 0", count, 0);
  endtask

  task automatic t_set_wins();
    clear_flag();
    ext_in = 1'b1; tick(2);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R9 set wins over clear", in_flag, 1);
    ext_in = 1'b0; tick(3);
    clear_flag();
  endtask

  task automatic t_gated_ratio(input logic [1:0] r, input int win, input int div);
    int c0;
    rate_sel = r; tick(300);
    clear_flag();
    c0 = count;
    ext_in = 1'b1; tick(win);
    ext_in = 1'b0; tick(4);
    chk($sformatf("R7 R6 gated rate %0d", r), count, (c0 + win / div) % 256);
    chk("R8 flag at gate end", in_flag, 1);
    c0 = count;
    tick(600);
    chk("R6 inactive no count", count, c0);
    clear_flag();
  endtask

  task automatic t_gated_low();
    int c0;
    gate_mode = 1'b0; ext_in = 1'b1; tick(4);
    polarity = 1'b0; gate_mode = 1'b1; rate_sel = 2'b01; tick(20);
    clear_flag();
    c0 = count;
    chk("R6 high inactive pol0", in_flag, 0);
    ext_in = 1'b0; tick(40);
    ext_in = 1'b1; tick(4);
    chk("R6 low active count", count, (c0 + 10) % 256);
    chk("R8 flag low gate end", in_flag, 1);
    clear_flag();
  endtask

  task automatic t_rate_restart();
    int c0;
    rate_sel = 2'b10; ext_in = 1'b0; tick(50);
    rate_sel = 2'b01;
    c0 = count;
    tick(4);
    chk("R12 hold after rate change", count, c0);
    tick(1);
    chk("R12 first tick after restart", count, (c0 + 1) % 256);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_sync_latency();
    t_clear_and_opposite();
    t_falling_polarity();
    t_fast_pulses();
    t_wrap();
    t_set_wins();
    gate_mode = 1'b1; polarity = 1'b1; ext_in = 1'b0; tick(4);
    t_gated_ratio(2'b00, 20, 1);
    t_gated_ratio(2'b01, 40, 4);
    t_gated_ratio(2'b10, 320, 32);
    t_gated_ratio(2'b11, 512, 256);
    t_gated_low();
    t_rate_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule